// File: doc/BRIEF.md
# DDR SDRAM Command Bus Protocol Monitor

This block sits beside the command bus of a four-bank double-data-rate SDRAM and watches it without driving anything. On every rising clock it turns the clock enable, chip select, row strobe, column strobe, write enable, bank select and address lines into one command. It keeps track of which banks have an open row and whether the device is powered down or in self-refresh. It also follows the mode-register settle window and any write burst that ends in an automatic precharge. When it sees a command that the device would not accept, it latches a sticky error flag together with a code that says which rule was broken.

A verification environment or an on-chip debug path instantiates the monitor with the burst length and the row precharge time of the attached controller. After reset the monitor runs on its own. The first violation stays visible on the error outputs until the next reset.

Top module: `ddr_cmd_monitor`

## Requirements
- R1: A command is decoded only when clock enable was high on the previous edge and is high on this one and chip select is low. The `{rasN,casN,weN}` value 000 is mode set, 001 is refresh, 010 is precharge, 011 is activate, 100 is write, 101 is read, 110 is burst stop and 111 is no operation. The bank index is `ba` (0 to 3), and an activate opens bank `ba`, which is shown as bit `ba` of `bankOpen`.
- R2: A precharge with `addr[AP_BIT]` high closes all four banks whatever `ba` holds. With that bit low it closes only bank `ba`.
- R3: A read or write to a bank without an open row sets error code 1.
- R4: An activate to a bank that already has an open row sets error code 2 and leaves `bankOpen` unchanged.
- R5: A mode set while any bank is open sets error code 3. With all banks idle it is legal.
- R6: After a legal mode set, any command other than no operation in either of the next two cycles sets error code 4. A command in the third cycle is accepted.
- R7: An auto refresh, or a self-refresh entry (a refresh encoding while clock enable falls), sets error code 5 when any bank is open.
- R8: A write with `addr[AP_BIT]` high keeps its bank open for BURST_LEN/2 cycles after the command. A read or write to any bank in those cycles sets error code 6. Once they are over, the bank reads as idle and accesses to other open banks are legal.
- R9: An activate to the bank of an auto-precharged write is rejected with code 7 for T_RP cycles after its burst ends. The earliest legal activate comes BURST_LEN/2 + T_RP + 1 cycles after the write.
- R10: Burst stop is legal in any state. A read with `addr[AP_BIT]` high closes its bank right after the command.
- R11: A fall of clock enable without a refresh encoding sets `powerDown`, and a fall with one sets `selfRefresh`. A rise of clock enable clears both. Commands sampled while clock enable is low, or on the rising edge itself, have no effect on state or errors.
- R12: Reset clears all outputs. The first error sets `errFlag` and its code, and neither changes again until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| cke | input | 1 | Clock enable |
| csN | input | 1 | Chip select, active low |
| rasN | input | 1 | Row strobe, active low |
| casN | input | 1 | Column strobe, active low |
| weN | input | 1 | Write enable, active low |
| ba | input | 2 | Bank select |
| addr | input | ADDR_W | Address bus; bit AP_BIT is the auto-precharge/all-banks bit |
| errFlag | output | 1 | Sticky error flag |
| errCode | output | 4 | Code of the first violation (0 when none) |
| bankOpen | output | 4 | One bit per bank, set while a row is open |
| selfRefresh | output | 1 | Device is in self-refresh |
| powerDown | output | 1 | Device is in power-down |

## Verification
The assertions assume that clock enable is held high through reset and for the first cycle after it. This keeps the checker's own clock-enable history in step with the monitor's. The stimulus meets this by driving every reset sequence with clock enable high and only lowering it in the power-down and self-refresh cases. The bench then sweeps the gap between a mode set or an auto-precharged write and the next command over every offset around each window edge. Expected codes come from BURST_LEN/2, T_RP and the two-cycle settle window.

// File: rtl/ddrmon_pkg.sv
`timescale 1ns/1ps
package ddrmon_pkg;

  localparam int NUM_BANKS = 4;
  localparam int BANK_W    = 2;
  localparam int ERR_W     = 4;

  typedef enum logic [ERR_W-1:0] {
    ERR_NONE        = 4'd0,
    ERR_IDLE_ACCESS = 4'd1,
    ERR_ROW_BUSY    = 4'd2,
    ERR_MRS_BUSY    = 4'd3,
    ERR_MRS_GAP     = 4'd4,
    ERR_REF_BUSY    = 4'd5,
    ERR_WAP_LOCK    = 4'd6,
    ERR_RP_EARLY    = 4'd7
  } errCode_e;

  // strobes handed from the decode datapath to the control
  typedef struct packed {
    logic act;
    logic rd;
    logic wr;
    logic pre;
    logic preAll;
    logic aRef;
    logic mrs;
    logic bst;
    logic srEnter;
    logic pdEnter;
    logic lowExit;
    logic autoPre;
    logic [NUM_BANKS-1:0] bankSel;
  } cmdStrobe_t;

endpackage

// File: rtl/ddrmon_decode.sv
`timescale 1ns/1ps
module ddrmon_decode
  import ddrmon_pkg::*;
#(
  parameter int ADDR_W = 13,
  parameter int AP_BIT = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cke,
  input  logic              csN,
  input  logic              rasN,
  input  logic              casN,
  input  logic              weN,
  input  logic [BANK_W-1:0] ba,
  input  logic [ADDR_W-1:0] addr,
  output cmdStrobe_t        strobe
);

  localparam logic [2:0] OPC_MRS = 3'b000;
  localparam logic [2:0] OPC_REF = 3'b001;
  localparam logic [2:0] OPC_PRE = 3'b010;
  localparam logic [2:0] OPC_ACT = 3'b011;
  localparam logic [2:0] OPC_WR  = 3'b100;
  localparam logic [2:0] OPC_RD  = 3'b101;
  localparam logic [2:0] OPC_BST = 3'b110;

  logic ckePrev;
  logic live;
  logic [2:0] opc;
  logic [NUM_BANKS-1:0] bankSel;
  logic unusedAddr;

  always_ff @(posedge clk) begin
    if (rst) ckePrev <= 1'b1;
    else     ckePrev <= cke;
  end

  assign unusedAddr = ^addr;
  assign opc  = {rasN, casN, weN};
  assign live = ckePrev & cke & ~csN;

  for (genvar gb = 0; gb < NUM_BANKS; gb++) begin : gSel
    assign bankSel[gb] = (ba == BANK_W'(gb));
  end

  always_comb begin
    strobe         = '0;
    strobe.bankSel = bankSel;
    strobe.autoPre = addr[AP_BIT];
    strobe.act     = live && (opc == OPC_ACT);
    strobe.rd      = live && (opc == OPC_RD);
    strobe.wr      = live && (opc == OPC_WR);
    strobe.pre     = live && (opc == OPC_PRE);
    strobe.preAll  = live && (opc == OPC_PRE) && addr[AP_BIT];
    strobe.aRef    = live && (opc == OPC_REF);
    strobe.mrs     = live && (opc == OPC_MRS);
    strobe.bst     = live && (opc == OPC_BST);
    strobe.srEnter = ckePrev && !cke && !csN && (opc == OPC_REF);
    strobe.pdEnter = ckePrev && !cke && !(!csN && (opc == OPC_REF));
    strobe.lowExit = !ckePrev && cke;
  end

endmodule

// File: rtl/ddrmon_ctrl.sv
`timescale 1ns/1ps
module ddrmon_ctrl
  import ddrmon_pkg::*;
#(
  parameter int BURST_LEN = 4,
  parameter int T_RP      = 3
) (
  input  logic                 clk,
  input  logic                 rst,
  input  cmdStrobe_t           strobe,
  output logic                 errFlag,
  output logic [ERR_W-1:0]     errCode,
  output logic [NUM_BANKS-1:0] bankOpen,
  output logic                 selfRefresh,
  output logic                 powerDown
);

  localparam int HALF  = BURST_LEN / 2;
  localparam int WAP_W = $clog2(HALF + 1);
  localparam int RP_W  = $clog2(T_RP + 1);
  localparam int GAP   = 2;
  localparam logic [WAP_W-1:0] WAP_ONE  = 1;
  localparam logic [WAP_W-1:0] WAP_LOAD = WAP_W'(HALF);
  localparam logic [RP_W-1:0]  RP_ONE   = 1;
  localparam logic [RP_W-1:0]  RP_LOAD  = RP_W'(T_RP);
  localparam logic [1:0]       GAP_LOAD = 2'(GAP);

  logic [WAP_W-1:0]     wapCnt;
  logic [NUM_BANKS-1:0] wapBank;
  logic [1:0]           gapCnt;
  logic [NUM_BANKS-1:0] rpBusyVec;
  logic [NUM_BANKS-1:0] nextOpen;
  errCode_e             newErr;
  logic wapBusy, wapEnd, targetOpen, rpBusy, anyCmd, cmdOk;

  assign wapBusy    = (wapCnt != '0);
  assign wapEnd     = (wapCnt == WAP_ONE);
  assign targetOpen = |(bankOpen & strobe.bankSel);
  assign rpBusy     = |(rpBusyVec & strobe.bankSel);
  assign anyCmd     = strobe.act | strobe.rd | strobe.wr | strobe.pre |
                      strobe.aRef | strobe.mrs | strobe.bst;

  // rule priority: settle window, write lockout, then per-command rules
  always_comb begin
    newErr = ERR_NONE;
    if ((gapCnt != '0) && anyCmd)                     newErr = ERR_MRS_GAP;
    else if ((strobe.rd || strobe.wr) && wapBusy)     newErr = ERR_WAP_LOCK;
    else if ((strobe.rd || strobe.wr) && !targetOpen) newErr = ERR_IDLE_ACCESS;
    else if (strobe.act && rpBusy)                    newErr = ERR_RP_EARLY;
    else if (strobe.act && targetOpen)                newErr = ERR_ROW_BUSY;
    else if (strobe.mrs && (|bankOpen))               newErr = ERR_MRS_BUSY;
    else if ((strobe.aRef || strobe.srEnter) && (|bankOpen))
                                                      newErr = ERR_REF_BUSY;
  end

  assign cmdOk = (newErr == ERR_NONE);

  always_comb begin
    nextOpen = bankOpen;
    if (wapEnd) nextOpen = nextOpen & ~wapBank;
    if (cmdOk) begin
      if (strobe.act)                    nextOpen = nextOpen | strobe.bankSel;
      if (strobe.preAll)                 nextOpen = '0;
      else if (strobe.pre)               nextOpen = nextOpen & ~strobe.bankSel;
      if (strobe.rd && strobe.autoPre)   nextOpen = nextOpen & ~strobe.bankSel;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) bankOpen <= '0;
    else     bankOpen <= nextOpen;
  end

  // write-with-auto-precharge burst tracker
  always_ff @(posedge clk) begin
    if (rst) begin
      wapCnt  <= '0;
      wapBank <= '0;
    end else if (cmdOk && strobe.wr && strobe.autoPre) begin
      wapCnt  <= WAP_LOAD;
      wapBank <= strobe.bankSel;
    end else if (wapBusy) begin
      wapCnt  <= wapCnt - WAP_ONE;
    end
  end

  // per-bank row precharge timers, started when an auto-precharge burst ends
  for (genvar gb = 0; gb < NUM_BANKS; gb++) begin : gRp
    logic [RP_W-1:0] cnt;
    always_ff @(posedge clk) begin
      if (rst)                      cnt <= '0;
      else if (wapEnd && wapBank[gb]) cnt <= RP_LOAD;
      else if (cnt != '0)           cnt <= cnt - RP_ONE;
    end
    assign rpBusyVec[gb] = (cnt != '0);
  end

  // mode-register settle window
  always_ff @(posedge clk) begin
    if (rst)                    gapCnt <= '0;
    else if (cmdOk && strobe.mrs) gapCnt <= GAP_LOAD;
    else if (gapCnt != '0)      gapCnt <= gapCnt - 2'd1;
  end

  // low-power modes
  always_ff @(posedge clk) begin
    if (rst || strobe.lowExit) begin
      selfRefresh <= 1'b0;
      powerDown   <= 1'b0;
    end else if (strobe.srEnter) begin
      selfRefresh <= 1'b1;
    end else if (strobe.pdEnter) begin
      powerDown   <= 1'b1;
    end
  end

  // first error is latched
  always_ff @(posedge clk) begin
    if (rst) begin
      errFlag <= 1'b0;
      errCode <= '0;
    end else if (!errFlag && !cmdOk) begin
      errFlag <= 1'b1;
      errCode <= newErr;
    end
  end

endmodule

// File: rtl/ddr_cmd_monitor.sv
`timescale 1ns/1ps
module ddr_cmd_monitor
  import ddrmon_pkg::*;
#(
  parameter int BURST_LEN = 4,
  parameter int T_RP      = 3,
  parameter int ADDR_W    = 13,
  parameter int AP_BIT    = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cke,
  input  logic              csN,
  input  logic              rasN,
  input  logic              casN,
  input  logic              weN,
  input  logic [1:0]        ba,
  input  logic [ADDR_W-1:0] addr,
  output logic              errFlag,
  output logic [3:0]        errCode,
  output logic [3:0]        bankOpen,
  output logic              selfRefresh,
  output logic              powerDown
);

  cmdStrobe_t strobe;

  ddrmon_decode #(.ADDR_W(ADDR_W), .AP_BIT(AP_BIT)) u_decode (
    .clk(clk), .rst(rst), .cke(cke), .csN(csN), .rasN(rasN), .casN(casN),
    .weN(weN), .ba(ba), .addr(addr), .strobe(strobe)
  );

  ddrmon_ctrl #(.BURST_LEN(BURST_LEN), .T_RP(T_RP)) u_ctrl (
    .clk(clk), .rst(rst), .strobe(strobe), .errFlag(errFlag),
    .errCode(errCode), .bankOpen(bankOpen), .selfRefresh(selfRefresh),
    .powerDown(powerDown)
  );

endmodule

// File: rtl/ddr_cmd_monitor_chk.sv
`timescale 1ns/1ps
module ddr_cmd_monitor_chk #(
  parameter int ADDR_W = 13,
  parameter int AP_BIT = 10
) (
  input logic              clk,
  input logic              rst,
  input logic              cke,
  input logic              csN,
  input logic              rasN,
  input logic              casN,
  input logic              weN,
  input logic [1:0]        ba,
  input logic [ADDR_W-1:0] addr,
  input logic              errFlag,
  input logic [3:0]        errCode,
  input logic [3:0]        bankOpen,
  input logic              selfRefresh,
  input logic              powerDown
);

  logic ckeSeen;
  logic live, isAct, isAcc, isPreAll;
  logic unusedAddr;

  always_ff @(posedge clk) begin
    if (rst) ckeSeen <= 1'b1;
    else     ckeSeen <= cke;
  end

  assign unusedAddr = ^addr;
  assign live     = ckeSeen && cke && !csN;
  assign isAct    = live && ({rasN, casN, weN} == 3'b011);
  assign isAcc    = live && !rasN == 1'b0 && !casN && 1'b1;
  assign isPreAll = live && ({rasN, casN, weN} == 3'b010) && addr[AP_BIT];

  // R2
  pre_all_clears_chk: assert property (@(posedge clk) disable iff (rst)
    isPreAll |=> (bankOpen == 4'b0000));

  // R3
  idle_access_err_chk: assert property (@(posedge clk) disable iff (rst)
    (isAcc && !bankOpen[ba]) |=> errFlag);

  // R4
  row_busy_err_chk: assert property (@(posedge clk) disable iff (rst)
    (isAct && bankOpen[ba]) |=> errFlag);

  // R11
  mode_exclusive_chk: assert property (@(posedge clk) disable iff (rst)
    !(selfRefresh && powerDown));

  // R11
  wake_clears_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(cke) |=> (!selfRefresh && !powerDown));

  // R12
  sticky_err_chk: assert property (@(posedge clk) disable iff (rst)
    errFlag |=> (errFlag && $stable(errCode)));

  // R12
  code_matches_flag_chk: assert property (@(posedge clk) disable iff (rst)
    errFlag == (errCode != 4'd0));

endmodule

bind ddr_cmd_monitor ddr_cmd_monitor_chk #(.ADDR_W(ADDR_W), .AP_BIT(AP_BIT)) u_chk (
  .clk(clk), .rst(rst), .cke(cke), .csN(csN), .rasN(rasN), .casN(casN),
  .weN(weN), .ba(ba), .addr(addr), .errFlag(errFlag), .errCode(errCode),
  .bankOpen(bankOpen), .selfRefresh(selfRefresh), .powerDown(powerDown)
);

// File: tb/sim_ddr_cmd_monitor.sv
`timescale 1ns/1ps
module sim_ddr_cmd_monitor;

  localparam int BL     = 4;
  localparam int TRP    = 3;
  localparam int ADDR_W = 13;
  localparam int AP_BIT = 10;
  localparam int HALF   = BL / 2;

  localparam logic [2:0] OP_MRS = 3'b000;
  localparam logic [2:0] OP_REF = 3'b001;
  localparam logic [2:0] OP_PRE = 3'b010;
  localparam logic [2:0] OP_ACT = 3'b011;
  localparam logic [2:0] OP_WR  = 3'b100;
  localparam logic [2:0] OP_RD  = 3'b101;
  localparam logic [2:0] OP_BST = 3'b110;
  localparam logic [2:0] OP_NOP = 3'b111;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cke = 1'b1;
  logic csN = 1'b1;
  logic rasN = 1'b1, casN = 1'b1, weN = 1'b1;
  logic [1:0] ba = '0;
  logic [ADDR_W-1:0] addr = '0;
  logic errFlag, selfRefresh, powerDown;
  logic [3:0] errCode, bankOpen;

  int nChecks = 0;
  int nErrs   = 0;
  bit done    = 1'b0;

  always #2.5 clk = ~clk;

  ddr_cmd_monitor #(.BURST_LEN(BL), .T_RP(TRP), .ADDR_W(ADDR_W), .AP_BIT(AP_BIT)) u0 (
    .clk(clk), .rst(rst), .cke(cke), .csN(csN), .rasN(rasN), .casN(casN),
    .weN(weN), .ba(ba), .addr(addr), .errFlag(errFlag), .errCode(errCode),
    .bankOpen(bankOpen), .selfRefresh(selfRefresh), .powerDown(powerDown)
  );

  task automatic check(input string tag, input int act, input int exp);
    nChecks++;
    if (act !== exp) begin
      nErrs++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // drive at a falling edge, pass one rising edge, return at the next falling edge
  task automatic step(input logic ckeV, input logic csV, input logic [2:0] opc,
                      input int bank, input logic ap);
    cke = ckeV; csN = csV; {rasN, casN, weN} = opc;
    ba = 2'(bank); addr = '0; addr[AP_BIT] = ap;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic cmd(input logic [2:0] opc, input int bank, input logic ap);
    step(1'b1, 1'b0, opc, bank, ap);
  endtask

  task automatic nops(input int n);
    for (int i = 0; i < n; i++) step(1'b1, 1'b1, OP_NOP, 0, 1'b0);
  endtask

  task automatic doReset();
    rst = 1'b1;
    nops(2);
    rst = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nErrs++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", nErrs, nChecks);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    doReset();
    // R12 reset state
    check("R12 reset errFlag", errFlag, 0);
    check("R12 reset errCode", errCode, 0);
    check("R12 reset bankOpen", bankOpen, 0);
    check("R11 reset modes", {selfRefresh, powerDown}, 0);

    // R1 bank decode per bank
    for (int b = 0; b < 4; b++) begin
      doReset();
      cmd(OP_ACT, b, 1'b0);
      check("R1 activate bank", bankOpen, 1 << b);
      cmd(OP_RD, b, 1'b0);
      cmd(OP_WR, b, 1'b0);
      check("R1 access open bank", errFlag, 0);
      cmd(OP_PRE, b, 1'b0);
      check("R2 single precharge", bankOpen, 0);
    end

    // R2 all-bank precharge ignores bank bits
    for (int s = 0; s < 4; s++) begin
      doReset();
      for (int b = 0; b < 4; b++) cmd(OP_ACT, b, 1'b0);
      cmd(OP_PRE, s, 1'b1);
      check("R2 precharge all", bankOpen, 0);
      check("R2 precharge all no error", errFlag, 0);
    end
    doReset();
    for (int b = 0; b < 4; b++) cmd(OP_ACT, b, 1'b0);
    cmd(OP_PRE, 2, 1'b0);
    check("R2 precharge one of four", bankOpen, 4'b1011);

    // R3 access to idle bank
    for (int b = 0; b < 4; b++) begin
      doReset();
      cmd(OP_ACT, (b + 1) % 4, 1'b0);
      cmd(OP_RD, b, 1'b0);
      check("R3 read idle bank", errCode, 1);
      doReset();
      cmd(OP_WR, b, 1'b0);
      check("R3 write idle bank", errCode, 1);
    end

    // R4 activate to open bank
    doReset();
    cmd(OP_ACT, 1, 1'b0);
    cmd(OP_ACT, 1, 1'b0);
    check("R4 double activate code", errCode, 2);
    check("R4 bankOpen unchanged", bankOpen, 4'b0010);

    // R5 mode set preconditions
    doReset();
    cmd(OP_ACT, 3, 1'b0);
    cmd(OP_MRS, 0, 1'b0);
    check("R5 mode set with open bank", errCode, 3);
    doReset();
    cmd(OP_MRS, 0, 1'b0);
    nops(2);
    check("R5 mode set idle legal", errFlag, 0);

    // R6 settle window sweep
    for (int k = 1; k <= 3; k++) begin
      doReset();
      cmd(OP_MRS, 0, 1'b0);
      nops(k - 1);
      cmd(OP_ACT, 0, 1'b0);
      check("R6 gap code", errCode, (k <= 2) ? 4 : 0);
      check("R6 gap bank state", bankOpen, (k <= 2) ? 0 : 1);
    end

    // R7 refresh preconditions
    doReset();
    cmd(OP_REF, 0, 1'b0);
    check("R7 refresh idle legal", errFlag, 0);
    cmd(OP_ACT, 0, 1'b0);
    cmd(OP_REF, 0, 1'b0);
    check("R7 refresh with open bank", errCode, 5);
    doReset();
    cmd(OP_ACT, 2, 1'b0);
    step(1'b0, 1'b0, OP_REF, 0, 1'b0);
    check("R7 self-refresh with open bank", errCode, 5);
    check("R11 self-refresh flag", selfRefresh, 1);

    // R8 write auto-precharge lockout sweep
    for (int k = 1; k <= HALF + 1; k++) begin
      doReset();
      cmd(OP_ACT, 0, 1'b0);
      cmd(OP_ACT, 1, 1'b0);
      cmd(OP_WR, 0, 1'b1);
      nops(k - 1);
      cmd(OP_RD, 1, 1'b0);
      check("R8 lockout code", errCode, (k <= HALF) ? 6 : 0);
      if (k > HALF) check("R8 bank closed after burst", bankOpen, 4'b0010);
    end

    // R9 precharge time sweep after auto-precharged write
    for (int d = 1; d <= HALF + TRP + 1; d++) begin
      doReset();
      cmd(OP_ACT, 0, 1'b0);
      cmd(OP_WR, 0, 1'b1);
      nops(d - 1);
      cmd(OP_ACT, 0, 1'b0);
      check("R9 reactivate code", errCode, (d <= HALF) ? 2 : ((d <= HALF + TRP) ? 7 : 0));
      if (d == HALF + TRP + 1) check("R9 reactivate opens", bankOpen, 1);
    end

    // R10 burst stop and read auto-precharge
    doReset();
    cmd(OP_BST, 0, 1'b0);
    cmd(OP_ACT, 0, 1'b0);
    cmd(OP_BST, 3, 1'b0);
    check("R10 burst stop legal", errFlag, 0);
    cmd(OP_RD, 0, 1'b1);
    check("R10 read auto-precharge closes", bankOpen, 0);
    check("R10 read auto-precharge no error", errFlag, 0);

    // R11 power-down and self-refresh
    doReset();
    cmd(OP_ACT, 1, 1'b0);
    step(1'b0, 1'b1, OP_NOP, 0, 1'b0);
    check("R11 power-down entry", {selfRefresh, powerDown}, 1);
    step(1'b0, 1'b0, OP_RD, 0, 1'b0);
    check("R11 command while low ignored", errFlag, 0);
    step(1'b1, 1'b0, OP_RD, 0, 1'b0);
    check("R11 power-down exit", {selfRefresh, powerDown}, 0);
    check("R11 exit edge ignored", errFlag, 0);
    check("R11 bank kept", bankOpen, 4'b0010);
    doReset();
    step(1'b0, 1'b0, OP_REF, 0, 1'b0);
    check("R11 self-refresh entry", {selfRefresh, powerDown}, 2);
    step(1'b0, 1'b0, OP_ACT, 0, 1'b0);
    step(1'b1, 1'b1, OP_NOP, 0, 1'b0);
    check("R11 self-refresh exit", {selfRefresh, powerDown}, 0);
    check("R11 activate while low ignored", bankOpen, 0);
    check("R11 idle self-refresh no error", errFlag, 0);

    // R12 sticky first error
    doReset();
    cmd(OP_RD, 0, 1'b0);
    cmd(OP_ACT, 0, 1'b0);
    cmd(OP_ACT, 0, 1'b0);
    check("R12 first code kept", errCode, 1);
    check("R12 flag kept", errFlag, 1);
    doReset();
    check("R12 reset clears", {errFlag, errCode}, 0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", nErrs, nChecks);
    $finish;
  end

endmodule